// File: doc/BRIEF.md
# SDRAM Power-Up and Refresh Sequencer

This block owns the command pins of a single-rank SDR SDRAM for everything that is not a data access. After reset it waits out the power-up pause, precharges every bank, issues the initial burst of auto-refresh commands and programs the mode register. Only then does it raise `ready`, which tells the access arbiter that the bus is free for reads and writes. All timing limits are parameters counted in clock cycles. The power-up pause is derived from a pause length in nanoseconds and the clock period.

In normal operation an interval timer raises `ref_req` once the average refresh spacing has elapsed. The arbiter answers with `ref_gnt` when the banks are idle, and the sequencer then places one auto-refresh on the bus. If the request is left waiting past a lateness limit, the grant produces two auto-refresh commands one row cycle apart. A self-refresh request is honoured only when no refresh is due. The block drops the clock enable together with an auto-refresh command and holds it low until the request is withdrawn. After that it keeps the bus quiet long enough for the device to complete a synchronous exit.

Top module: `sdram_refresh_seq`

## Requirements
- R1: From reset, and for PWRUP_CYC = ceil(POWERUP_NS*1000/CLK_PS) rising edges after reset is released, the bus carries only NOP, `cke` is high and `ready`, `ref_req` and `sr_ack` are low. The first other command appears on edge PWRUP_CYC+1.
- R2: Commands are coded on {cs_n,ras_n,cas_n,we_n} as NOP 0111, PRECHARGE 0010, AUTO REFRESH 0001 and MODE REGISTER SET 0000. Initialisation issues one PRECHARGE with `addr[10]` high, then exactly INIT_REFS auto-refresh commands, then one mode register set.
- R3: During mode register set `ba` is zero and `addr` holds the following fields. Bits [2:0] carry the burst code (1→000, 2→001, 4→010, 8→011, full page with BURST_LEN=0→111). Bit [3] is 1 for interleaved wrap. Bits [6:4] carry the CAS latency. All higher bits are zero.
- R4: A command follows a PRECHARGE by exactly T_RP cycles during initialisation and by at least T_RP otherwise. It follows an AUTO REFRESH by at least T_RC cycles. Only NOP appears in between.
- R5: `ready` first rises exactly T_MRD cycles after the mode register set. It is low whenever the sequencer has a command in flight, and it rises again T_RC-1 cycles after a refresh command.
- R6: `ref_req` rises REFI_CYC cycles after the last refresh command or mode register set, provided `ready` is high. A grant sampled while `ref_req` is high puts one AUTO REFRESH (with `cke` high) on the next cycle. A grant while `ref_req` is low does nothing.
- R7: If REF_LATE_CYC cycles have passed since the last refresh when the grant arrives, two AUTO REFRESH commands are issued exactly T_RC cycles apart.
- R8: With `sr_req` high, `ready` high and no refresh due, the next command is AUTO REFRESH with `cke` driven low and `sr_ack` raised. While `cke` stays low only NOP is driven and `ref_req` stays low.
- R9: A due refresh wins over a self-refresh request. While `ref_req` is high and not yet granted, `cke` stays high.
- R10: One cycle after `sr_req` is seen low in self-refresh, `cke` rises and `sr_ack` falls. No command and no `ready` follows until `ready` rises T_RC+1 cycles after `cke`, so the first command lands T_RC cycles after the second edge that sees `cke` high.
- R11: The refresh interval timer restarts when self-refresh ends, so `ref_req` rises REFI_CYC cycles after `cke` returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_gnt | input | 1 | Arbiter allows the pending refresh |
| sr_req | input | 1 | Level request to stay in self-refresh |
| ready | output | 1 | Bus free for the arbiter's own commands |
| ref_req | output | 1 | Refresh due, waiting for a grant |
| sr_ack | output | 1 | Device is in self-refresh |
| cke | output | 1 | Clock enable to the device |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | BA_W | Bank address, zero for all issued commands |
| addr | output | ADDR_W | Address bus: bit 10 for precharge-all, mode word for register set |

## Verification
The bench times every command edge against its neighbours. It first checks the power-up pause and the order precharge-all, eight refreshes, mode set. Off-by-one loading of the pause or wait counters shows up there as a command one cycle early or late. A grant while no refresh is due is applied to catch a sequencer that refreshes on any grant. A grant is also held off well past the lateness limit, where a design missing the recovery issues a single refresh, or issues the pair closer than a row cycle. Self-refresh is requested while a refresh is due, which exposes a design that lowers the clock enable with a refresh still owed. On exit, a design that counts the row-cycle wait from the edge that raises the clock enable, rather than from the second edge that samples it, raises `ready` too early. A design that forgets to restart the interval timer asks for refresh at the wrong time.

// File: rtl/sdram_refresh_seq.sv
module sdram_refresh_seq #(
  parameter int CLK_PS           = 10000,
  parameter int POWERUP_NS       = 100000,
  parameter int T_RP             = 2,
  parameter int T_RC             = 7,
  parameter int T_MRD            = 2,
  parameter int INIT_REFS        = 8,
  parameter int REFI_CYC         = 1560,
  parameter int REF_LATE_CYC     = 12480,
  parameter int CAS_LAT          = 2,
  parameter int BURST_LEN        = 4,
  parameter int BURST_INTERLEAVE = 0,
  parameter int ADDR_W           = 12,
  parameter int BA_W             = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_gnt,
  input  logic              sr_req,
  output logic              ready,
  output logic              ref_req,
  output logic              sr_ack,
  output logic              cke,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [BA_W-1:0]   ba,
  output logic [ADDR_W-1:0] addr
);

  localparam int PWRUP_CYC = (POWERUP_NS * 1000 + CLK_PS - 1) / CLK_PS;
  localparam int WAIT_MAX  = (PWRUP_CYC > T_RC + 1) ? PWRUP_CYC : T_RC + 1;
  localparam int WAIT_TOP  = (WAIT_MAX > T_MRD) ? WAIT_MAX : T_MRD;
  localparam int WAIT_W    = $clog2(WAIT_TOP + 1);
  localparam int REF_W     = $clog2(REF_LATE_CYC + 1);
  localparam int INIT_W    = $clog2(INIT_REFS + 1);

  localparam logic [2:0] BL_CODE = (BURST_LEN == 1) ? 3'd0 :
                                   (BURST_LEN == 2) ? 3'd1 :
                                   (BURST_LEN == 4) ? 3'd2 :
                                   (BURST_LEN == 8) ? 3'd3 : 3'd7;
  localparam logic [6:0] MODE_LOW  = {3'(CAS_LAT), 1'(BURST_INTERLEAVE), BL_CODE};
  localparam logic [ADDR_W-1:0] MODE_WORD = ADDR_W'(MODE_LOW);

  localparam logic [3:0] C_NOP  = 4'b0111;
  localparam logic [3:0] C_PRE  = 4'b0010;
  localparam logic [3:0] C_AREF = 4'b0001;
  localparam logic [3:0] C_MRS  = 4'b0000;

  typedef enum logic [2:0] {
    S_PWRUP, S_INIT_AR, S_MRS, S_IDLE, S_REF2, S_SELF
  } state_t;

  state_t            state;
  logic [WAIT_W-1:0] wcnt;
  logic [INIT_W-1:0] arleft;
  logic [REF_W-1:0]  rcnt;
  logic [3:0]        cmd;

  logic due, late, running;

  assign due     = rcnt >= REF_W'(REFI_CYC);
  assign late    = rcnt >= REF_W'(REF_LATE_CYC);
  assign running = (state == S_IDLE) || (state == S_REF2);

  assign ready   = (state == S_IDLE) && (wcnt == '0);
  assign ref_req = ready && due;
  assign sr_ack  = (state == S_SELF);

  assign {cs_n, ras_n, cas_n, we_n} = cmd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_PWRUP;
      wcnt   <= WAIT_W'(PWRUP_CYC);
      arleft <= INIT_W'(INIT_REFS);
      rcnt   <= '0;
      cmd    <= C_NOP;
      cke    <= 1'b1;
      addr   <= '0;
      ba     <= '0;
    end else begin
      cmd  <= C_NOP;
      addr <= '0;
      ba   <= '0;
      if (running && !late)
        rcnt <= rcnt + 1'b1;
      if (wcnt != '0) begin
        wcnt <= wcnt - 1'b1;
      end else begin
        case (state)
          S_PWRUP: begin
            cmd      <= C_PRE;
            addr[10] <= 1'b1;
            wcnt     <= WAIT_W'(T_RP - 1);
            state    <= S_INIT_AR;
          end
          S_INIT_AR: begin
            cmd    <= C_AREF;
            wcnt   <= WAIT_W'(T_RC - 1);
            arleft <= arleft - 1'b1;
            if (arleft == INIT_W'(1))
              state <= S_MRS;
          end
          S_MRS: begin
            cmd   <= C_MRS;
            addr  <= MODE_WORD;
            wcnt  <= WAIT_W'(T_MRD);
            rcnt  <= '0;
            state <= S_IDLE;
          end
          S_IDLE: begin
            if (due && ref_gnt) begin
              cmd  <= C_AREF;
              wcnt <= WAIT_W'(T_RC - 1);
              rcnt <= '0;
              if (late)
                state <= S_REF2;
            end else if (!due && sr_req) begin
              cmd   <= C_AREF;
              cke   <= 1'b0;
              rcnt  <= '0;
              state <= S_SELF;
            end
          end
          S_REF2: begin
            cmd   <= C_AREF;
            wcnt  <= WAIT_W'(T_RC - 1);
            rcnt  <= '0;
            state <= S_IDLE;
          end
          S_SELF: begin
            rcnt <= '0;
            if (!sr_req) begin
              cke   <= 1'b1;
              wcnt  <= WAIT_W'(T_RC + 1);
              state <= S_IDLE;
            end
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/sdram_refresh_seq_chk.sv
module sdram_refresh_seq_chk #(
  parameter int T_RP      = 2,
  parameter int T_RC      = 7,
  parameter int T_MRD     = 2,
  parameter int PWRUP_CYC = 10
) (
  input logic clk,
  input logic rst_n,
  input logic cke,
  input logic cs_n,
  input logic ras_n,
  input logic cas_n,
  input logic we_n,
  input logic a10,
  input logic ready,
  input logic ref_req,
  input logic ref_gnt,
  input logic sr_req,
  input logic sr_ack
);

  localparam logic [3:0] C_NOP  = 4'b0111;
  localparam logic [3:0] C_PRE  = 4'b0010;
  localparam logic [3:0] C_AREF = 4'b0001;
  localparam logic [3:0] C_MRS  = 4'b0000;

  logic [3:0]  cmd, last;
  logic [31:0] boot, gap, since_mrs, since_cke;
  logic        any_seen, mrs_seen, cke_d;

  assign cmd = {cs_n, ras_n, cas_n, we_n};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      boot      <= '0;
      gap       <= '0;
      last      <= C_NOP;
      any_seen  <= 1'b0;
      mrs_seen  <= 1'b0;
      since_mrs <= '0;
      since_cke <= 32'(T_RC + 2);
      cke_d     <= 1'b1;
    end else begin
      cke_d <= cke;
      if (boot < 32'(PWRUP_CYC + 2)) boot <= boot + 1;
      if (cmd != C_NOP) begin
        last     <= cmd;
        gap      <= 32'd1;
        any_seen <= 1'b1;
      end else if (gap < 32'(T_RC + T_RP + 2)) begin
        gap <= gap + 1;
      end
      if (cmd == C_MRS) begin
        mrs_seen  <= 1'b1;
        since_mrs <= 32'd1;
      end else if (since_mrs < 32'(T_MRD + 2)) begin
        since_mrs <= since_mrs + 1;
      end
      if (cke && !cke_d) since_cke <= 32'd1;
      else if (since_cke < 32'(T_RC + 2)) since_cke <= since_cke + 1;
    end
  end

  AST_PWRUP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (boot < 32'(PWRUP_CYC)) |-> (cmd == C_NOP && cke && !ready));        // R1
  AST_FIRST_PRE_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd != C_NOP && !any_seen) |-> (cmd == C_PRE && a10));              // R2
  AST_GAP_AFTER_PRE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd != C_NOP && last == C_PRE) |-> (gap >= 32'(T_RP)));             // R4
  AST_GAP_AFTER_AREF: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd != C_NOP && last == C_AREF) |-> (gap >= 32'(T_RC)));            // R4
  AST_READY_AFTER_MRS: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (mrs_seen && since_mrs >= 32'(T_MRD)));                    // R5
  AST_GRANT_REFRESH: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_req && ref_gnt) |=> (cmd == C_AREF && cke));                    // R6
  AST_SELF_CKE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    sr_ack |-> !cke);                                                    // R8
  AST_SELF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke && !$past(cke)) |-> (cmd == C_NOP && !ref_req));               // R8
  AST_REFRESH_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_req && sr_req && !ref_gnt) |=> cke);                            // R9
  AST_EXIT_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd != C_NOP && cke) |-> (since_cke >= 32'(T_RC + 2)));             // R10

endmodule

bind sdram_refresh_seq sdram_refresh_seq_chk #(
  .T_RP(T_RP), .T_RC(T_RC), .T_MRD(T_MRD), .PWRUP_CYC(PWRUP_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
  .cas_n(cas_n), .we_n(we_n), .a10(addr[10]), .ready(ready),
  .ref_req(ref_req), .ref_gnt(ref_gnt), .sr_req(sr_req), .sr_ack(sr_ack)
);

// File: tb/sim_sdram_refresh_seq.sv
module sim_sdram_refresh_seq;

  localparam int CLK_PS = 8000;
  localparam int PWR_NS = 400;
  localparam int PWR    = (PWR_NS * 1000 + CLK_PS - 1) / CLK_PS;
  localparam int TRP    = 2;
  localparam int TRC    = 7;
  localparam int TMRD   = 2;
  localparam int NINIT  = 8;
  localparam int REFI   = 60;
  localparam int LATE   = 150;

  localparam logic [3:0] NOP  = 4'b0111;
  localparam logic [3:0] PRE  = 4'b0010;
  localparam logic [3:0] AREF = 4'b0001;
  localparam logic [3:0] MRS  = 4'b0000;
  localparam logic [11:0] MODE_EXP = 12'h03B;

  logic clk = 1'b0, rst_n = 1'b0, ref_gnt = 1'b0, sr_req = 1'b0;
  logic ready, ref_req, sr_ack, cke, cs_n, ras_n, cas_n, we_n;
  logic [1:0]  ba;
  logic [11:0] addr;

  sdram_refresh_seq #(
    .CLK_PS(CLK_PS), .POWERUP_NS(PWR_NS), .T_RP(TRP), .T_RC(TRC), .T_MRD(TMRD),
    .INIT_REFS(NINIT), .REFI_CYC(REFI), .REF_LATE_CYC(LATE), .CAS_LAT(3),
    .BURST_LEN(8), .BURST_INTERLEAVE(1), .ADDR_W(12), .BA_W(2)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .ref_gnt(ref_gnt), .sr_req(sr_req),
    .ready(ready), .ref_req(ref_req), .sr_ack(sr_ack), .cke(cke),
    .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr)
  );

  always #4 clk = ~clk;

  int ncyc = 0;
  always @(posedge clk) ncyc <= ncyc + 1;

  int nchk = 0, nfail = 0;
  int t_pre, t_mrs, t_last;

  function automatic logic [3:0] bus();
    return {cs_n, ras_n, cas_n, we_n};
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_cmd(output logic [3:0] c, output int at);
    c = NOP; at = -1;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (bus() != NOP) begin c = bus(); at = ncyc; return; end
    end
  endtask

  task automatic wait_ready(output int at, output int extra_cmds);
    at = -1; extra_cmds = 0;
    for (int i = 0; i < 3000; i++) begin
      if (ready) begin at = ncyc; return; end
      @(negedge clk);
      if (bus() != NOP) extra_cmds++;
    end
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check("R1 reset bus NOP", int'(bus()), int'(NOP));
    check("R1 reset cke high", int'(cke), 1);
    check("R1 reset flags low", int'({ready, ref_req, sr_ack}), 0);
  endtask

  task automatic t_powerup();
    int nops = 0;
    rst_n = 1'b1;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (bus() != NOP) break;
      nops++;
    end
    check("R1 power-up NOP cycles", nops, PWR);
    check("R2 first command PRECHARGE", int'(bus()), int'(PRE));
    check("R2 precharge-all addr10", int'(addr[10]), 1);
    t_pre = ncyc;
  endtask

  task automatic t_init_seq();
    logic [3:0] c; int at; int bad = 0;
    for (int i = 0; i < NINIT; i++) begin
      wait_cmd(c, at);
      if (c != AREF || at != t_pre + TRP + i * TRC || ready) bad++;
    end
    check("R2 R4 init refresh count and spacing", bad, 0);
    wait_cmd(c, at);
    check("R2 mode set after refreshes", int'(c), int'(MRS));
    check("R4 mode set spacing", at, t_pre + TRP + NINIT * TRC);
    check("R3 mode word", int'(addr), int'(MODE_EXP));
    check("R3 bank zero", int'(ba), 0);
    t_mrs = at;
    wait_ready(at, bad);
    check("R5 ready after mode set", at, t_mrs + TMRD);
    t_last = t_mrs;
  endtask

  task automatic t_ignore_grant();
    int bad = 0;
    ref_gnt = 1'b1;
    repeat (8) begin
      @(negedge clk);
      if (bus() != NOP || ref_req) bad++;
    end
    ref_gnt = 1'b0;
    check("R6 grant without request ignored", bad, 0);
  endtask

  task automatic grant_one(input string tag, output int at);
    ref_gnt = 1'b1;
    @(negedge clk);
    ref_gnt = 1'b0;
    check({tag, " refresh on grant"}, int'({bus(), cke}), int'({AREF, 1'b1}));
    at = ncyc;
  endtask

  task automatic t_refresh();
    int at, ex;
    while (!ref_req) @(negedge clk);
    check("R6 request interval", ncyc, t_last + REFI);
    grant_one("R6", t_last);
    wait_ready(at, ex);
    check("R5 ready after single refresh", at, t_last + TRC - 1);
    check("R7 no second refresh when on time", ex, 0);
  endtask

  task automatic t_overdue();
    logic [3:0] c; int at, ex, first;
    while (ncyc < t_last + LATE + 5) @(negedge clk);
    check("R6 request held while waiting", int'(ref_req), 1);
    grant_one("R7", first);
    wait_cmd(c, at);
    check("R7 second refresh", int'(c), int'(AREF));
    check("R7 second refresh spacing", at, first + TRC);
    t_last = at;
    wait_ready(at, ex);
    check("R5 ready after double refresh", at, t_last + TRC - 1);
  endtask

  task automatic t_priority();
    logic [3:0] c; int at, bad = 0;
    while (!ref_req) @(negedge clk);
    check("R6 request interval after recovery", ncyc, t_last + REFI);
    sr_req = 1'b1;
    repeat (5) begin
      @(negedge clk);
      if (!cke || bus() != NOP || !ref_req) bad++;
    end
    check("R9 refresh owed blocks self-refresh", bad, 0);
    grant_one("R9", t_last);
    wait_cmd(c, at);
    check("R8 self-refresh entry command", int'(c), int'(AREF));
    check("R8 self-refresh entry timing", at, t_last + TRC);
    check("R8 cke low and ack", int'({cke, sr_ack}), 1);
  endtask

  task automatic t_self_exit();
    int bad = 0, at, ex, c_up;
    repeat (2 * REFI) begin
      @(negedge clk);
      if (cke || bus() != NOP || ref_req || ready || !sr_ack) bad++;
    end
    check("R8 self-refresh hold quiet", bad, 0);
    sr_req = 1'b0;
    @(negedge clk);
    check("R10 cke rises, ack falls", int'({cke, sr_ack}), 2);
    c_up = ncyc;
    wait_ready(at, ex);
    check("R10 exit wait before ready", at, c_up + TRC + 1);
    check("R10 no command during exit", ex, 0);
    while (!ref_req) @(negedge clk);
    check("R11 interval restarts after exit", ncyc, c_up + REFI);
    grant_one("R11", t_last);
  endtask

  initial begin
    repeat (30000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", ncyc, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    t_reset();
    @(negedge clk);
    t_powerup();
    t_init_seq();
    t_ignore_grant();
    t_refresh();
    t_overdue();
    t_priority();
    t_self_exit();
    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

endmodule